// File: doc/BRIEF.md
# Neighbour Stream Alignment Monitor

This block pairs a local sample stream with a sample stream that comes in from a neighbouring device over a chip-to-chip link. Local samples, each with a start-of-packet marker, are written into a small FIFO as they arrive. Each remote sample pops one local sample, and the pair is released together on the merged output. The local stream can therefore run ahead of the remote one by up to the FIFO depth.

While pairing, the block watches three error conditions and keeps one sticky flag for each. The first is a remote start-of-packet marker that does not coincide with the marker on the local sample leaving the FIFO. The second is a local write that arrives while the FIFO is full, meaning the remote data is late or missing. The third is a remote sample that arrives while the FIFO is empty, meaning the remote data is early.

A status word gives an overall OK bit and the three flags. A read strobe returns that word and clears the flags. An error raised in the same cycle as the read is kept for the next read.

Top module: `nbr_align_monitor`

## Requirements
- R1: Local samples leave the FIFO in the order they were written, one per remote sample, and appear on `pair_loc_data` alongside the remote sample on `pair_rem_data`.
- R2: `pair_valid` is 1 only in a cycle where `rem_valid` is 1 and the FIFO holds at least one local sample.
- R3: The misalignment flag is set when `rem_valid` is 1 and `rem_sop` differs from the start-of-packet marker of the local sample at the FIFO head. That marker counts as 0 when the FIFO is empty.
- R4: A local write while the FIFO holds DEPTH samples and no sample leaves in that cycle is dropped and sets the overflow flag. The stored samples are unchanged.
- R5: A remote sample while the FIFO is empty sets the underflow flag. In that cycle `pair_valid` is 0 and `pair_loc_data` is zero. A local write in the same cycle is stored and is not paired with that remote sample.
- R6: `stat_word` layout: bit 0 is OK and is 1 exactly when no flag is set; bit 1 is misalignment; bit 2 is overflow; bit 3 is underflow.
- R7: A flag becomes visible on `stat_word` in the cycle after its event. It stays set until a cycle with `stat_rd` = 1, which shows the current word and clears the flags at its clock edge.
- R8: An error event in the same cycle as `stat_rd` leaves its flag set after the clear. Flags without an event in that cycle are cleared.
- R9: After reset the FIFO is empty, all flags are clear, and `stat_word` is 4'b0001.
- R10: A local write to a full FIFO in the same cycle as a remote sample is accepted without overflow. The FIFO stays full and keeps its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_valid | input | 1 | Local sample present |
| loc_data | input | DW | Local sample |
| loc_sop | input | 1 | Local start-of-packet marker |
| rem_valid | input | 1 | Remote sample present; pops one local sample |
| rem_data | input | DW | Remote sample |
| rem_sop | input | 1 | Remote start-of-packet marker |
| pair_valid | output | 1 | Merged pair valid |
| pair_loc_data | output | DW | Local half of the pair (zero when empty) |
| pair_rem_data | output | DW | Remote half of the pair |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat_word | output | 4 | {underflow, overflow, misalign, ok} |

## Verification
The bench builds the block with DEPTH = 4 and DW = 8. With that depth, a full FIFO, a dropped fifth write, a write and read together while full, and pointer wrap-around all take only a handful of cycles. The 8-bit width keeps the sample tags short, and each one is unique, so any reordering or lost entry shows up in the paired data.

// File: rtl/nam_pkg.sv
package nam_pkg;

  typedef struct packed {
    logic underflow;
    logic overflow;
    logic misalign;
  } nam_flags_t;

  localparam int unsigned NAM_NFLAGS = 3;

  // Pointer advance with wrap for any depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Status word: {underflow, overflow, misalign, ok}.
  function automatic logic [3:0] pack_status(input nam_flags_t f);
    return {f.underflow, f.overflow, f.misalign, ~|f};
  endfunction

  // Occupancy after one cycle of push/pop.
  function automatic int unsigned next_count(input int unsigned c, input logic push, input logic pop);
    int unsigned r;
    r = c;
    if (push && !pop) r = c + 1;
    if (pop && !push) r = c - 1;
    return r;
  endfunction

endpackage

// File: rtl/nam_fifo.sv
module nam_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sop,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_sop,
  output logic          empty,
  output logic          full,
  output logic          rd_fire,
  output logic          wr_drop,
  output logic          rd_miss
);
  import nam_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          wr_fire;
  logic [EW-1:0] head;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign rd_fire = rd_req & ~empty;
  assign wr_fire = wr_req & (~full | rd_fire);
  assign wr_drop = wr_req & full & ~rd_fire;
  assign rd_miss = rd_req & empty;

  assign head    = mem[rptr];
  assign rd_data = empty ? '0 : head[DW-1:0];
  assign rd_sop  = empty ? 1'b0 : head[DW];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= {wr_sop, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_fire) wptr <= AW'(wrap_inc(int'(wptr), DEPTH));
      if (rd_fire) rptr <= AW'(rptr == AW'(DEPTH - 1) ? 0 : int'(rptr) + 1);
      count <= CW'(next_count(int'(count), wr_fire, rd_fire));
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> full);

  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |-> (rd_data == '0 && !rd_sop));

  // R10
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && rd_req) |=> full);

endmodule

// File: rtl/nam_boundary_cmp.sv
module nam_boundary_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic rem_valid,
  input  logic rem_sop,
  input  logic head_sop,
  input  logic head_present,
  output logic misalign_ev,
  output logic pair_ok
);
  assign misalign_ev = rem_valid & (rem_sop ^ head_sop);
  assign pair_ok     = rem_valid & head_present;

  // R2
  pair_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ok |-> (rem_valid && head_present));

  // R3
  sop_match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_valid && rem_sop == head_sop) |-> !misalign_ev);

endmodule

// File: rtl/nam_sticky_flags.sv
module nam_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set_ev[i] | (flags[i] & ~clr);
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr) |=> flags[i]);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_ev[i]) |=> !flags[i]);
  end

endmodule

// File: rtl/nbr_align_monitor.sv
module nbr_align_monitor #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_valid,
  input  logic [DW-1:0] loc_data,
  input  logic          loc_sop,
  input  logic          rem_valid,
  input  logic [DW-1:0] rem_data,
  input  logic          rem_sop,
  output logic          pair_valid,
  output logic [DW-1:0] pair_loc_data,
  output logic [DW-1:0] pair_rem_data,
  input  logic          stat_rd,
  output logic [3:0]    stat_word
);
  import nam_pkg::*;

  logic       head_sop, fifo_empty, fifo_full, pop_fire;
  logic       ev_overflow, ev_underflow, ev_misalign;
  logic [NAM_NFLAGS-1:0] ev_vec, flag_vec;
  nam_flags_t flags_s;

  nam_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_req(loc_valid), .wr_data(loc_data), .wr_sop(loc_sop),
    .rd_req(rem_valid), .rd_data(pair_loc_data), .rd_sop(head_sop),
    .empty(fifo_empty), .full(fifo_full), .rd_fire(pop_fire),
    .wr_drop(ev_overflow), .rd_miss(ev_underflow)
  );

  nam_boundary_cmp u_cmp (
    .clk(clk), .rst_n(rst_n),
    .rem_valid(rem_valid), .rem_sop(rem_sop),
    .head_sop(head_sop), .head_present(~fifo_empty),
    .misalign_ev(ev_misalign), .pair_ok(pair_valid)
  );

  assign ev_vec = {ev_underflow, ev_overflow, ev_misalign};

  nam_sticky_flags #(.N(NAM_NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_ev(ev_vec), .clr(stat_rd), .flags(flag_vec)
  );

  assign flags_s       = nam_flags_t'(flag_vec);
  assign stat_word     = pack_status(flags_s);
  assign pair_rem_data = rem_data;

  // R2
  pair_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid == pop_fire);

  // R5
  underflow_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |-> !pair_valid);

  // R6
  ok_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[0] |-> (flag_vec == '0));

  // R4
  overflow_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |-> fifo_full);

endmodule

// File: tb/sim_nbr_align_monitor.sv
module sim_nbr_align_monitor;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loc_valid = 0, loc_sop = 0, rem_valid = 0, rem_sop = 0, stat_rd = 0;
  logic [DW-1:0] loc_data = '0, rem_data = '0;
  logic pair_valid;
  logic [DW-1:0] pair_loc_data, pair_rem_data;
  logic [3:0] stat_word;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_align_monitor #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_sop(loc_sop),
    .rem_valid(rem_valid), .rem_data(rem_data), .rem_sop(rem_sop),
    .pair_valid(pair_valid), .pair_loc_data(pair_loc_data),
    .pair_rem_data(pair_rem_data), .stat_rd(stat_rd), .stat_word(stat_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs after a falling edge; outputs settle 1 time unit later.
  task automatic drive(input logic lv, input logic [DW-1:0] ld, input logic ls,
                       input logic rv, input logic [DW-1:0] rd, input logic rs,
                       input logic srd);
    @(negedge clk);
    loc_valid = lv; loc_data = ld; loc_sop = ls;
    rem_valid = rv; rem_data = rd; rem_sop = rs; stat_rd = srd;
    #1;
  endtask

  task automatic idle();
    drive(0, '0, 0, 0, '0, 0, 0);
  endtask

  task automatic clear_flags();
    drive(0, '0, 0, 0, '0, 0, 1);
    idle();
  endtask

  task automatic t_reset();
    check("R9 status after reset", stat_word, 4'b0001);
    check("R9 no pair after reset", pair_valid, 0);
  endtask

  task automatic t_order();
    drive(1, 8'hA0, 1, 0, '0, 0, 0);
    drive(1, 8'hA1, 0, 0, '0, 0, 0);
    drive(1, 8'hA2, 0, 0, '0, 0, 0);
    drive(0, '0, 0, 1, 8'hB0, 1, 0);
    check("R2 pair valid", pair_valid, 1);
    check("R1 first local", pair_loc_data, 8'hA0);
    check("R1 remote half", pair_rem_data, 8'hB0);
    drive(0, '0, 0, 1, 8'hB1, 0, 0);
    check("R1 second local", pair_loc_data, 8'hA1);
    drive(0, '0, 0, 1, 8'hB2, 0, 0);
    check("R1 third local", pair_loc_data, 8'hA2);
    idle();
    check("R2 no pair without remote", pair_valid, 0);
    check("R3 aligned markers keep ok", stat_word, 4'b0001);
  endtask

  task automatic t_misalign();
    drive(1, 8'hC0, 0, 0, '0, 0, 0);
    drive(0, '0, 0, 1, 8'hD0, 1, 0);
    check("R2 pair while misaligned", pair_valid, 1);
    idle();
    check("R3 misalign flag", stat_word, 4'b0010);
    idle(); idle();
    check("R7 flag held", stat_word, 4'b0010);
    drive(0, '0, 0, 0, '0, 0, 1);
    check("R7 read returns word", stat_word, 4'b0010);
    idle();
    check("R7 cleared by read", stat_word, 4'b0001);
  endtask

  task automatic t_overflow_underflow();
    for (int i = 0; i < 5; i++) drive(1, DW'(8'hE0 + i), 0, 0, '0, 0, 0);
    idle();
    check("R4 overflow flag", stat_word, 4'b0100);
    clear_flags();
    check("R7 overflow cleared", stat_word, 4'b0001);
    for (int i = 0; i < 4; i++) begin
      drive(0, '0, 0, 1, 8'h11, 0, 0);
      check("R4 kept samples in order", pair_loc_data, DW'(8'hE0 + i));
    end
    idle();
    check("R4 dropped write not stored", stat_word, 4'b0001);
    drive(0, '0, 0, 1, 8'h22, 0, 0);
    check("R5 no pair when empty", pair_valid, 0);
    check("R5 zero local data", pair_loc_data, 0);
    idle();
    check("R5 underflow flag", stat_word, 4'b1000);
    clear_flags();
  endtask

  task automatic t_full_pass();
    for (int i = 0; i < 4; i++) drive(1, DW'(8'h40 + i), 0, 0, '0, 0, 0);
    drive(1, 8'h44, 0, 1, 8'h55, 0, 0);
    check("R10 head pops while full", pair_loc_data, 8'h40);
    idle();
    check("R10 no overflow", stat_word, 4'b0001);
    for (int i = 1; i < 5; i++) begin
      drive(0, '0, 0, 1, 8'h55, 0, 0);
      check("R10 order after wrap", pair_loc_data, DW'(8'h40 + i));
    end
    idle();
    check("R10 still ok", stat_word, 4'b0001);
  endtask

  task automatic t_empty_same_cycle();
    drive(1, 8'h66, 0, 1, 8'h77, 0, 0);
    check("R5 write not paired same cycle", pair_valid, 0);
    idle();
    check("R5 underflow on empty", stat_word, 4'b1000);
    drive(0, '0, 0, 1, 8'h78, 0, 0);
    check("R5 write was stored", pair_loc_data, 8'h66);
    clear_flags();
    check("R7 clean after clear", stat_word, 4'b0001);
  endtask

  task automatic t_clear_race();
    for (int i = 0; i < 5; i++) drive(1, DW'(8'h90 + i), 0, 0, '0, 0, 0);
    for (int i = 0; i < 4; i++) drive(0, '0, 0, 1, 8'h01, 0, 0);
    drive(0, '0, 0, 1, 8'h02, 0, 1);
    check("R8 read returns prior flag", stat_word, 4'b0100);
    idle();
    check("R8 new event survives clear", stat_word, 4'b1000);
    clear_flags();
    check("R8 final clear", stat_word, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_order();
    t_misalign();
    t_overflow_underflow();
    t_full_pass();
    t_empty_same_cycle();
    t_clear_race();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule